// File: doc/BRIEF.md
# Per-Thread Resource Quota Enforcer

This block sits beside the front end of a two-thread simultaneous multithreaded core. It tracks how many instances of five shared back-end resources each thread currently holds: integer physical registers, floating-point physical registers, and entries in the integer, floating-point and load/store issue queues. Decode reports allocations as small per-cycle counts. Commit reports register releases, and issue reports queue-entry releases, also as counts.

Each thread has one quota register per resource. Every cycle the occupancy counters are compared with the quotas. A small per-thread state machine holds a fetch-stall line high while any of that thread's counters is above its quota. Software, or a dynamic partitioning controller, rewrites quotas through a single write port. After reset every quota equals the full size of its resource, so the core runs as an unpartitioned SMT until quotas are tightened.

Each per-thread machine has two states. `T_RUN` is the fetching state. `T_HOLD` is the fetch-stalled state. The `trip` transition goes from `T_RUN` to `T_HOLD` when some counter is over its quota. The `clear` transition goes from `T_HOLD` to `T_RUN` when all counters are back within their quotas. In every other case the state is kept.

Top module: `quota_enforcer`

## Requirements
- R1: After reset every occupancy counter reads 0 and both fetch-stall lines are low.
- R2: The allocate count for thread t and resource r is carried on `alloc_cnt[(t*5+r)*4 +: 4]`. It is added to that counter, and the new value appears on `usage[(t*5+r)*9 +: 9]` after the clock edge that sampled it. Resource codes are: 0 integer registers, 1 floating-point registers, 2 integer queue, 3 floating-point queue, 4 load/store queue.
- R3: When an allocate and a release hit the same counter in one cycle, the net change is applied in that single update. A counter never rises above its resource size (256 for registers, 64 for queues) and never falls below 0. Any excess is clipped.
- R4: Register releases come from commit on `commit_rel[(t*2+k)*4 +: 4]`, where k=0 is integer and k=1 is floating-point. Queue releases come from issue on `issue_rel[(t*3+q)*4 +: 4]`, where q=0 is integer, q=1 is floating-point and q=2 is load/store. Each release port changes only its own counter.
- R5: A thread's fetch-stall line rises one cycle after any of its counters first exceeds its quota (strictly greater than the quota).
- R6: A stalled thread's fetch-stall line falls one cycle after all of its counters are within quota. A counter equal to its quota does not stall.
- R7: When `quota_we` is high, the value on `quota_data` is written to the quota for thread `quota_thread` and resource `quota_res`, and takes effect from the next cycle. A write with `quota_res` of 5, 6 or 7 changes no quota.
- R8: With every quota at the reset value (the full resource size), no stall is ever raised, even at full occupancy.
- R9: Each thread's counters, quotas and stall line are independent of the other thread's traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_cnt | input | 40 | Per-thread, per-resource allocate counts from decode (0..8) |
| commit_rel | input | 16 | Per-thread register release counts from commit |
| issue_rel | input | 24 | Per-thread queue-entry release counts from issue |
| quota_we | input | 1 | Quota write strobe |
| quota_thread | input | 1 | Thread selected by a quota write |
| quota_res | input | 3 | Resource code selected by a quota write |
| quota_data | input | 9 | New quota value |
| usage | output | 90 | Occupancy counters, 9 bits each, indexed (t*5+r) |
| fetch_stall | output | 2 | Per-thread fetch-stall lines |

## Verification
A counter result is due one edge after the allocate or release counts are presented. A stall change is due one edge later still, because the state register reacts only to counters that are already updated. A quota write likewise changes the stall line at the second edge after the strobe. The bench drives inputs on falling edges and samples on the next falling edge. For stall transitions it checks both the sample where the line must still hold its old value and the sample one edge later where it must have changed.

// File: rtl/qe_pkg.sv
package qe_pkg;
    localparam int NUM_RES      = 5;
    localparam int NUM_REGFILES = 2;
    localparam int NUM_QUEUES   = 3;
    localparam int RES_W        = 3;

    typedef enum logic [RES_W-1:0] {
        RS_INT_REG = 3'd0,
        RS_FP_REG  = 3'd1,
        RS_INT_Q   = 3'd2,
        RS_FP_Q    = 3'd3,
        RS_LS_Q    = 3'd4
    } res_e;

    typedef enum logic {
        T_RUN  = 1'b0,
        T_HOLD = 1'b1
    } gate_e;
endpackage

// File: rtl/qe_counter.sv
module qe_counter #(
    parameter int CNT_W = 9,
    parameter int EV_W  = 4,
    parameter int SIZE  = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EV_W-1:0]  inc,
    input  logic [EV_W-1:0]  dec,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] nxt;
    int               sum;

    always_comb begin
        sum = int'(cnt) + int'(inc) - int'(dec);
        if (sum < 0)
            nxt = '0;
        else if (sum > SIZE)
            nxt = CNT_W'(SIZE);
        else
            nxt = CNT_W'(sum);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= nxt;
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) <= SIZE);
    p_balanced_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (inc == dec) |=> $stable(cnt));
    p_grow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc > dec) |=> (cnt >= $past(cnt)));
endmodule

// File: rtl/qe_quota_reg.sv
module qe_quota_reg #(
    parameter int CNT_W = 9,
    parameter int SIZE  = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] quota
);
    always_ff @(posedge clk) begin
        if (!rst_n)  quota <= CNT_W'(SIZE);
        else if (we) quota <= wdata;
    end

    p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(quota));
endmodule

// File: rtl/qe_stall_fsm.sv
module qe_stall_fsm
    import qe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic over,
    output logic stall
);
    gate_e state, state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            T_RUN:  if (over)  state_nxt = T_HOLD;  // trip
            T_HOLD: if (!over) state_nxt = T_RUN;   // clear
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= T_RUN;
        else        state <= state_nxt;
    end

    always_comb stall = (state == T_HOLD);

    p_trip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        over |=> stall);
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !over |=> !stall);
endmodule

// File: rtl/quota_enforcer.sv
module quota_enforcer
    import qe_pkg::*;
#(
    parameter int NUM_THREADS = 2,
    parameter int REG_SIZE    = 256,
    parameter int QUEUE_SIZE  = 64,
    parameter int MAX_EVENTS  = 8,
    localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
    localparam int EV_W  = $clog2(MAX_EVENTS + 1),
    localparam int CNT_W = $clog2(((REG_SIZE > QUEUE_SIZE) ? REG_SIZE : QUEUE_SIZE) + 1)
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [NUM_THREADS*NUM_RES*EV_W-1:0]      alloc_cnt,
    input  logic [NUM_THREADS*NUM_REGFILES*EV_W-1:0] commit_rel,
    input  logic [NUM_THREADS*NUM_QUEUES*EV_W-1:0]   issue_rel,
    input  logic                                 quota_we,
    input  logic [TID_W-1:0]                     quota_thread,
    input  logic [RES_W-1:0]                     quota_res,
    input  logic [CNT_W-1:0]                     quota_data,
    output logic [NUM_THREADS*NUM_RES*CNT_W-1:0] usage,
    output logic [NUM_THREADS-1:0]               fetch_stall
);
    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        logic [NUM_RES-1:0] over_r;
        logic               over;

        for (genvar r = 0; r < NUM_RES; r++) begin : g_res
            localparam int SZ = (r < NUM_REGFILES) ? REG_SIZE : QUEUE_SIZE;
            logic [EV_W-1:0]  rel;
            logic [CNT_W-1:0] cnt;
            logic [CNT_W-1:0] quota;
            logic             we;

            if (r < NUM_REGFILES) begin : g_commit
                assign rel = commit_rel[(t*NUM_REGFILES + r)*EV_W +: EV_W];
            end else begin : g_issue
                assign rel = issue_rel[(t*NUM_QUEUES + r - NUM_REGFILES)*EV_W +: EV_W];
            end

            assign we = quota_we && (quota_thread == TID_W'(t))
                        && (quota_res == RES_W'(r));

            qe_counter #(.CNT_W(CNT_W), .EV_W(EV_W), .SIZE(SZ)) u_cnt (
                .clk  (clk),
                .rst_n(rst_n),
                .inc  (alloc_cnt[(t*NUM_RES + r)*EV_W +: EV_W]),
                .dec  (rel),
                .cnt  (cnt)
            );

            qe_quota_reg #(.CNT_W(CNT_W), .SIZE(SZ)) u_quota (
                .clk  (clk),
                .rst_n(rst_n),
                .we   (we),
                .wdata(quota_data),
                .quota(quota)
            );

            assign over_r[r] = (cnt > quota);
            assign usage[(t*NUM_RES + r)*CNT_W +: CNT_W] = cnt;
        end

        assign over = |over_r;

        qe_stall_fsm u_fsm (
            .clk  (clk),
            .rst_n(rst_n),
            .over (over),
            .stall(fetch_stall[t])
        );
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (fetch_stall == '0));
endmodule

// File: tb/sim_quota_enforcer.sv
`timescale 1ns/1ps
module sim_quota_enforcer;
    localparam int NT = 2, NR = 5, EV_W = 4, CNT_W = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NT*NR*EV_W-1:0] alloc_cnt = '0;
    logic [NT*2*EV_W-1:0]  commit_rel = '0;
    logic [NT*3*EV_W-1:0]  issue_rel = '0;
    logic                  quota_we = 1'b0;
    logic                  quota_thread = 1'b0;
    logic [2:0]            quota_res = '0;
    logic [CNT_W-1:0]      quota_data = '0;
    logic [NT*NR*CNT_W-1:0] usage;
    logic [NT-1:0]         fetch_stall;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    quota_enforcer u0 (
        .clk(clk), .rst_n(rst_n), .alloc_cnt(alloc_cnt), .commit_rel(commit_rel),
        .issue_rel(issue_rel), .quota_we(quota_we), .quota_thread(quota_thread),
        .quota_res(quota_res), .quota_data(quota_data), .usage(usage),
        .fetch_stall(fetch_stall)
    );

    // vector: {alloc[3:0], commit release[3:0], expected count[11:0]} on thread 0 integer registers
    localparam int NV = 10;
    localparam logic [19:0] VEC [NV] = '{
        {4'd8, 4'd0, 12'd8},  {4'd8, 4'd0, 12'd16}, {4'd5, 4'd3, 12'd18},
        {4'd0, 4'd8, 12'd10}, {4'd4, 4'd4, 12'd10}, {4'd0, 4'd8, 12'd2},
        {4'd0, 4'd8, 12'd0},  {4'd3, 4'd0, 12'd3},  {4'd0, 4'd0, 12'd3},
        {4'd0, 4'd3, 12'd0}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int use_of(int t, int r);
        return int'(usage[(t*NR + r)*CNT_W +: CNT_W]);
    endfunction

    task automatic clear_in();
        alloc_cnt = '0; commit_rel = '0; issue_rel = '0; quota_we = 1'b0;
    endtask

    task automatic wr_quota(int t, int r, int v);
        quota_we = 1'b1; quota_thread = 1'(t); quota_res = 3'(r); quota_data = CNT_W'(v);
        tick();
        quota_we = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int t = 0; t < NT; t++)
            for (int r = 0; r < NR; r++)
                check("R1 usage", use_of(t, r), 0);
        check("R1 stall", int'(fetch_stall), 0);

        // R2/R3 vector walk: thread 0 integer registers
        for (int i = 0; i < NV; i++) begin
            alloc_cnt[0 +: EV_W] = VEC[i][19:16];
            commit_rel[0 +: EV_W] = VEC[i][15:12];
            tick();
            clear_in();
            check("R2/R3 net count", use_of(0, 0), int'(VEC[i][11:0]));
            check("R8 no stall", int'(fetch_stall[0]), 0);
        end

        // R3 clip at full size, thread 0 integer queue (size 64)
        alloc_cnt[(0*NR + 2)*EV_W +: EV_W] = 4'd8;
        repeat (9) tick();
        clear_in();
        check("R3 clip high", use_of(0, 2), 64);
        tick();
        check("R8 full no stall", int'(fetch_stall[0]), 0);
        alloc_cnt[(0*NR + 2)*EV_W +: EV_W] = 4'd8;
        issue_rel[0 +: EV_W] = 4'd8;
        tick();
        clear_in();
        check("R3 same-cycle at full", use_of(0, 2), 64);
        issue_rel[0 +: EV_W] = 4'd8;
        repeat (9) tick();
        clear_in();
        check("R3 clip low", use_of(0, 2), 0);

        // R4 release routing
        alloc_cnt[(0*NR + 1)*EV_W +: EV_W] = 4'd5;
        tick();
        clear_in();
        check("R4 fp reg alloc", use_of(0, 1), 5);
        issue_rel[1*EV_W +: EV_W] = 4'd4;
        commit_rel[0 +: EV_W] = 4'd3;
        tick();
        clear_in();
        check("R4 fp queue release leaves fp reg", use_of(0, 1), 5);
        check("R4 fp queue floor", use_of(0, 3), 0);
        commit_rel[1*EV_W +: EV_W] = 4'd2;
        tick();
        clear_in();
        check("R4 fp reg commit release", use_of(0, 1), 3);

        // R7 invalid resource code ignored
        wr_quota(0, 5, 0);
        tick();
        check("R7 code 5 ignored", int'(fetch_stall[0]), 0);
        wr_quota(0, 7, 0);
        tick();
        check("R7 code 7 ignored", int'(fetch_stall[0]), 0);

        // R7/R5/R6 quota write on fp registers (count 3)
        wr_quota(0, 1, 2);
        check("R5 latency hold", int'(fetch_stall[0]), 0);
        tick();
        check("R5 R7 stall after quota write", int'(fetch_stall[0]), 1);
        wr_quota(0, 1, 256);
        check("R6 latency hold", int'(fetch_stall[0]), 1);
        tick();
        check("R6 stall cleared", int'(fetch_stall[0]), 0);

        // R5/R6/R9 thread 1 load/store queue
        wr_quota(1, 4, 4);
        alloc_cnt[(1*NR + 4)*EV_W +: EV_W] = 4'd4;
        tick();
        clear_in();
        tick();
        check("R6 equal to quota", int'(fetch_stall[1]), 0);
        alloc_cnt[(1*NR + 4)*EV_W +: EV_W] = 4'd1;
        tick();
        clear_in();
        check("R2 thread1 count", use_of(1, 4), 5);
        check("R5 not yet", int'(fetch_stall[1]), 0);
        tick();
        check("R5 over quota", int'(fetch_stall[1]), 1);
        check("R9 other thread free", int'(fetch_stall[0]), 0);
        check("R9 other thread count", use_of(0, 4), 0);
        issue_rel[(1*3 + 2)*EV_W +: EV_W] = 4'd1;
        tick();
        clear_in();
        check("R4 ls release", use_of(1, 4), 4);
        check("R6 still held", int'(fetch_stall[1]), 1);
        tick();
        check("R6 released", int'(fetch_stall[1]), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule